// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block is the sending half of a serial port. Software, or any upstream producer, hands it one data word at a time through a valid/ready write port. The word waits in a one-entry holding buffer and then moves into a shift register. The shift register sends it as an asynchronous frame. A frame has a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts sixteen pulses of an external baud tick. The line rests high between frames.

Two sticky conditions are reported apart from each other. The buffer-empty flag means a new word may be written. The frame-done flag means the line has gone quiet with nothing left to send. Each flag has its own enable and its own interrupt request. The frame-done flag is cleared by a status write of 0 or by an acknowledge pulse. When the transmit enable is dropped, the frame already being shifted still completes, and the pin-ownership output then falls.

Back-pressure on the write port works like this. `wr_ready` is high exactly while the buffer is empty. A beat transfers on a clock edge where `wr_valid` and `wr_ready` are both high. A `wr_valid` raised while `wr_ready` is low is ignored, and the word already held is kept. The frame layout (`cfg_len`, `par_mode`, `two_stop`) is captured when a word enters the shift register, so a change made during a frame affects only the next frame.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` = 1, `buf_empty` = 1, `wr_ready` = 1, `tx_done` = 0, both interrupt requests are 0, and `pin_own` = 0 when `tx_en` = 0.
- R2: A frame on `txd` is: one start bit of 0, then the data bits LSB first, then the stop bit(s) at 1. The number of data bits is `cfg_len` + 5 for codes 0..4. Codes 5..7 act as 9. Data bits above the selected length are not sent.
- R3: The parity bit is present when `par_mode[1]` = 1, and it sits between the last data bit and the first stop bit. `par_mode[0]` = 1 selects odd parity: data bits plus parity have an odd count of ones. `par_mode[0]` = 0 selects even parity. When `par_mode[1]` = 0, `par_mode[0]` has no effect.
- R4: With `two_stop` = 0 the frame has one stop bit. With `two_stop` = 1 it has two. `tx_done` can rise only at the baud tick that ends the last stop bit.
- R5: Every bit lasts 16 baud ticks, and `txd` changes only on a clock edge where `baud_tick` is 1.
- R6: When the shifter is idle, the buffer holds a word and `tx_en` = 1, the word enters the shift register on the next baud tick. The start bit begins at that tick, and `buf_empty` becomes 1 at the same edge.
- R7: An accepted write stores `wr_data` and clears `buf_empty`. A write while `buf_empty` = 0 is ignored, and `wr_ready` = 0 in that state.
- R8: `tx_done` sets at the end of a frame only if the holding buffer is empty at that moment. If another word is waiting, `tx_done` stays 0.
- R9: `tx_done` clears on a `stat_wr` pulse with `stat_done_wdata` = 0, or on a `done_ack` pulse. A `stat_wr` with `stat_done_wdata` = 1 leaves it unchanged.
- R10: `irq_empty` = `buf_empty` AND `ie_empty`, and `irq_done` = `tx_done` AND `ie_done`, held for as long as both inputs are 1.
- R11: Clearing `tx_en` during a frame lets that frame finish unchanged. No further word is loaded while `tx_en` = 0, and a held word waits until `tx_en` returns to 1.
- R12: `pin_own` is 1 while `tx_en` = 1 or a frame is in progress. While `pin_own` = 0, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| cfg_len | input | 3 | Data length code, bits = code + 5 (5..7 act as 9) |
| par_mode | input | 2 | [1] parity on, [0] odd parity |
| two_stop | input | 1 | 1 selects two stop bits |
| ie_empty | input | 1 | Buffer-empty interrupt enable |
| ie_done | input | 1 | Frame-done interrupt enable |
| baud_tick | input | 1 | One-cycle pulse at 16x bit rate |
| wr_valid | input | 1 | Write beat valid |
| wr_data | input | 9 | Write data word |
| wr_ready | output | 1 | Buffer can accept a word |
| stat_wr | input | 1 | Status write strobe |
| stat_done_wdata | input | 1 | Value written to the frame-done bit (0 clears) |
| done_ack | input | 1 | Frame-done interrupt acknowledge pulse |
| txd | output | 1 | Serial output, idles high |
| pin_own | output | 1 | Transmitter owns the serial pin |
| buf_empty | output | 1 | Holding buffer empty flag |
| tx_done | output | 1 | Frame-done flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Frame-done interrupt request |

## Verification
The assertions assume three things about the inputs. `baud_tick` is a single-cycle pulse that never stays high on two edges in a row. `done_ack` and `stat_wr` are one-cycle strobes. Reset is held for at least one edge. The stimulus creates ticks with a free-running divider that pulses once every four clocks. It drives every strobe for exactly one cycle on the falling edge, and it changes `tx_en` and the frame layout only between frames. The one exception is the deliberate disable in the middle of a frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W        = 9;
  localparam int MIN_BITS      = 5;
  localparam int TICKS_PER_BIT = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP1 = 3'd4,
    ST_STOP2 = 3'd5
  } tx_state_t;
endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          load,
  output logic [DW-1:0] hold_data,
  output logic          buf_empty
);
  logic empty_q;
  logic [DW-1:0] data_q;
  logic accept;

  assign accept = wr_valid && empty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      data_q  <= '0;
    end else begin
      if (accept) begin
        data_q  <= wr_data;
        empty_q <= 1'b0;
      end else if (load) begin
        empty_q <= 1'b1;
      end
    end
  end

  assign wr_ready  = empty_q;
  assign buf_empty = empty_q;
  assign hold_data = data_q;
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int TPB = TICKS_PER_BIT,
  parameter int MNB = MIN_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          baud_tick,
  input  logic          buf_full,
  input  logic [DW-1:0] hold_data,
  input  logic [2:0]    cfg_len,
  input  logic [1:0]    par_mode,
  input  logic          two_stop,
  output logic          load,
  output logic          busy,
  output logic          frame_end,
  output logic          txd
);
  localparam int TCW = (TPB > 1) ? $clog2(TPB) : 1;
  localparam int BCW = $clog2(DW + 1);

  tx_state_t state_q;
  logic [TCW-1:0] tick_cnt;
  logic [BCW-1:0] bit_idx;
  logic [BCW-1:0] nbits_q;
  logic [DW-1:0]  shreg;
  logic           par_en_q, par_bit_q, stop2_q;
  logic           bit_end;
  logic [BCW-1:0] nbits_sel;
  logic [DW-1:0]  len_mask;
  logic           par_calc;

  always_comb begin
    if (cfg_len > 3'(DW - MNB)) nbits_sel = BCW'(DW);
    else                        nbits_sel = BCW'(cfg_len) + BCW'(MNB);
  end

  generate
    for (genvar g = 0; g < DW; g++) begin : g_mask
      assign len_mask[g] = (BCW'(g) < nbits_sel);
    end
  endgenerate

  assign par_calc = (^(hold_data & len_mask)) ^ par_mode[0];

  assign load    = (state_q == ST_IDLE) && buf_full && tx_en && baud_tick;
  assign bit_end = baud_tick && (tick_cnt == TCW'(TPB - 1));
  assign frame_end = bit_end &&
                     (((state_q == ST_STOP1) && !stop2_q) || (state_q == ST_STOP2));
  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tick_cnt  <= '0;
      bit_idx   <= '0;
      nbits_q   <= '0;
      shreg     <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      stop2_q   <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (load) begin
        state_q   <= ST_START;
        tick_cnt  <= '0;
        bit_idx   <= '0;
        shreg     <= hold_data;
        nbits_q   <= nbits_sel;
        par_en_q  <= par_mode[1];
        par_bit_q <= par_calc;
        stop2_q   <= two_stop;
      end
    end else if (baud_tick) begin
      if (!bit_end) begin
        tick_cnt <= tick_cnt + 1'b1;
      end else begin
        tick_cnt <= '0;
        unique case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            shreg   <= shreg >> 1;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == nbits_q - 1'b1)
              state_q <= par_en_q ? ST_PAR : ST_STOP1;
          end
          ST_PAR:   state_q <= ST_STOP1;
          ST_STOP1: state_q <= stop2_q ? ST_STOP2 : ST_IDLE;
          ST_STOP2: state_q <= ST_IDLE;
          default:  state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      ST_PAR:   txd = par_bit_q;
      default:  txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/sertx_flags.sv
module sertx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic buf_empty,
  input  logic stat_wr,
  input  logic stat_done_wdata,
  input  logic done_ack,
  input  logic ie_empty,
  input  logic ie_done,
  output logic tx_done,
  output logic irq_empty,
  output logic irq_done
);
  logic done_q;
  logic set_done, clr_done;

  assign set_done = frame_end && buf_empty;
  assign clr_done = done_ack || (stat_wr && !stat_done_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (set_done) done_q <= 1'b1;
    else if (clr_done) done_q <= 1'b0;
  end

  assign tx_done   = done_q;
  assign irq_done  = done_q && ie_done;
  assign irq_empty = buf_empty && ie_empty;
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int TPB = TICKS_PER_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic [2:0]    cfg_len,
  input  logic [1:0]    par_mode,
  input  logic          two_stop,
  input  logic          ie_empty,
  input  logic          ie_done,
  input  logic          baud_tick,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          stat_wr,
  input  logic          stat_done_wdata,
  input  logic          done_ack,
  output logic          txd,
  output logic          pin_own,
  output logic          buf_empty,
  output logic          tx_done,
  output logic          irq_empty,
  output logic          irq_done
);
  logic          load, busy, frame_end;
  logic [DW-1:0] hold_data;

  sertx_holdbuf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .load(load), .hold_data(hold_data), .buf_empty(buf_empty)
  );

  sertx_shifter #(.DW(DW), .TPB(TPB), .MNB(MIN_BITS)) u_shf (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
    .buf_full(!buf_empty), .hold_data(hold_data),
    .cfg_len(cfg_len), .par_mode(par_mode), .two_stop(two_stop),
    .load(load), .busy(busy), .frame_end(frame_end), .txd(txd)
  );

  sertx_flags u_flg (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .buf_empty(buf_empty),
    .stat_wr(stat_wr), .stat_done_wdata(stat_done_wdata), .done_ack(done_ack),
    .ie_empty(ie_empty), .ie_done(ie_done),
    .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done)
  );

  assign pin_own = tx_en || busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic baud_tick,
  input logic wr_valid,
  input logic wr_ready,
  input logic buf_empty,
  input logic tx_done,
  input logic txd,
  input logic pin_own,
  input logic done_ack,
  input logic stat_wr,
  input logic stat_done_wdata
);
  // R7
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !buf_empty);

  // R6
  empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(baud_tick && tx_en));

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (buf_empty && $past(baud_tick)));

  // R9
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_done) |-> $past(done_ack || (stat_wr && !stat_done_wdata)));

  // R5
  txd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(baud_tick));

  // R12
  pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_own |-> txd);
endmodule

bind sertx_top sertx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .buf_empty(buf_empty),
  .tx_done(tx_done), .txd(txd), .pin_own(pin_own), .done_ack(done_ack),
  .stat_wr(stat_wr), .stat_done_wdata(stat_done_wdata)
);

// File: tb/sertx_top_tb.sv
`timescale 1ns/1ps
module sertx_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic [2:0] cfg_len = 3'd3;
  logic [1:0] par_mode = 2'b00;
  logic two_stop = 1'b0;
  logic ie_empty = 1'b0, ie_done = 1'b0;
  logic baud_tick = 1'b0;
  logic wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic wr_ready;
  logic stat_wr = 1'b0, stat_done_wdata = 1'b1, done_ack = 1'b0;
  logic txd, pin_own, buf_empty, tx_done, irq_empty, irq_done;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [1:0] tdiv = '0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv      <= tdiv + 1'b1;
    baud_tick <= (tdiv == 2'd3);
  end

  sertx_top dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cfg_len(cfg_len),
    .par_mode(par_mode), .two_stop(two_stop), .ie_empty(ie_empty),
    .ie_done(ie_done), .baud_tick(baud_tick), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .stat_wr(stat_wr),
    .stat_done_wdata(stat_done_wdata), .done_ack(done_ack), .txd(txd),
    .pin_own(pin_own), .buf_empty(buf_empty), .tx_done(tx_done),
    .irq_empty(irq_empty), .irq_done(irq_done)
  );

  // {data[8:0], len[2:0], par_mode[1:0], two_stop, expected parity}
  localparam logic [15:0] VEC [6] = '{
    {9'h055, 3'd3, 2'b10, 1'b0, 1'b0},
    {9'h1A5, 3'd4, 2'b11, 1'b0, 1'b0},
    {9'h1F3, 3'd0, 2'b10, 1'b1, 1'b1},
    {9'h07F, 3'd2, 2'b00, 1'b1, 1'b0},
    {9'h03C, 3'd1, 2'b11, 1'b0, 1'b1},
    {9'h0FF, 3'd3, 2'b01, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic write_data(input logic [8:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic clear_done();
    @(negedge clk);
    stat_wr = 1'b1; stat_done_wdata = 1'b0;
    @(negedge clk);
    stat_wr = 1'b0; stat_done_wdata = 1'b1;
  endtask

  task automatic wait_start();
    for (int k = 0; k < 5000 && txd !== 1'b0; k++) @(negedge clk);
    chk("R2", txd, 1'b0, "start bit not seen");
  endtask

  task automatic check_frame(input logic [8:0] d, input logic [2:0] len,
                             input logic [1:0] pm, input logic st2, input logic ep,
                             input logic exp_done);
    int nd;
    int bad;
    nd = (len > 3'd4) ? 9 : int'(len) + 5;
    bad = 0;
    wait_start();
    chk("R6", buf_empty, 1'b1, "buf_empty at load");
    wait_ticks(8);
    if (txd !== 1'b0) bad++;
    for (int i = 0; i < nd; i++) begin
      wait_ticks(16);
      if (txd !== d[i]) bad++;
    end
    chk("R2/R5", 16'(bad), 16'd0, "data bit mismatches");
    if (pm[1]) begin
      wait_ticks(16);
      chk("R3", txd, ep, "parity bit");
    end
    wait_ticks(16);
    chk("R2", txd, 1'b1, "first stop bit");
    if (st2) begin
      wait_ticks(16);
      chk("R4", txd, 1'b1, "second stop bit");
    end
    chk("R4", tx_done, 1'b0, "done in last stop");
    wait_ticks(8);
    chk("R8", tx_done, exp_done, "done after last stop");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", txd, 1'b1, "txd idle");
    chk("R1", buf_empty, 1'b1, "buf_empty");
    chk("R1", wr_ready, 1'b1, "wr_ready");
    chk("R1", tx_done, 1'b0, "tx_done");
    chk("R1", {irq_empty, irq_done}, 2'b00, "irqs");
    chk("R12", pin_own, 1'b0, "pin_own while disabled");

    tx_en = 1'b1;
    @(negedge clk);
    chk("R12", pin_own, 1'b1, "pin_own when enabled");

    // vector table
    foreach (VEC[v]) begin
      cfg_len  = VEC[v][6:4];
      par_mode = VEC[v][3:2];
      two_stop = VEC[v][1];
      write_data(VEC[v][15:7]);
      chk("R7", buf_empty, 1'b0, "buf_empty after write");
      check_frame(VEC[v][15:7], VEC[v][6:4], VEC[v][3:2], VEC[v][1], VEC[v][0], 1'b1);
      clear_done();
    end

    // R10 / R9 flags and requests
    cfg_len = 3'd3; par_mode = 2'b00; two_stop = 1'b0;
    write_data(9'h0A3);
    check_frame(9'h0A3, 3'd3, 2'b00, 1'b0, 1'b0, 1'b1);
    ie_done = 1'b1; ie_empty = 1'b1;
    @(negedge clk);
    chk("R10", {irq_done, irq_empty}, 2'b11, "both requests");
    ie_done = 1'b0;
    @(negedge clk);
    chk("R10", irq_done, 1'b0, "done request masked");
    ie_done = 1'b1;
    @(negedge clk);
    stat_wr = 1'b1; stat_done_wdata = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0;
    chk("R9", tx_done, 1'b1, "write 1 keeps done");
    done_ack = 1'b1;
    @(negedge clk);
    done_ack = 1'b0;
    chk("R9", {tx_done, irq_done}, 2'b00, "ack clears done");
    ie_done = 1'b0; ie_empty = 1'b0;

    // R7 write ignored while full
    tx_en = 1'b0;
    write_data(9'h0C5);
    chk("R7", wr_ready, 1'b0, "wr_ready when full");
    chk("R10", irq_empty, 1'b0, "empty request off when full");
    write_data(9'h03A);
    tx_en = 1'b1;
    check_frame(9'h0C5, 3'd3, 2'b00, 1'b0, 1'b0, 1'b1);
    clear_done();

    // R8 back-to-back frames
    write_data(9'h011);
    wait_start();
    write_data(9'h0EE);
    wait_ticks(8 + 16 * 9);
    chk("R8", tx_done, 1'b0, "done withheld with word waiting");
    check_frame(9'h0EE, 3'd3, 2'b00, 1'b0, 1'b0, 1'b1);
    clear_done();

    // R11 disable mid-frame
    write_data(9'h096);
    wait_start();
    tx_en = 1'b0;
    write_data(9'h069);
    chk("R12", pin_own, 1'b1, "pin_own during draining frame");
    wait_ticks(8);
    for (int i = 0; i < 8; i++) begin
      wait_ticks(16);
      chk("R11", txd, 1'(9'h096 >> i), "draining frame data bit");
    end
    wait_ticks(16 + 40);
    chk("R11", {txd, buf_empty}, 2'b10, "no load while disabled");
    chk("R12", pin_own, 1'b0, "pin released after frame");
    tx_en = 1'b1;
    check_frame(9'h069, 3'd3, 2'b00, 1'b0, 1'b0, 1'b1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule